// File: doc/BRIEF.md
# Global Reset Source Recorder

This block sits in the always-on part of a chip and decides when the whole system is put through a global reset. Fifteen request lines can start one: a temperature sensor alarm, an error-monitor alarm, a system panic, a security violation, a self-test failure, two watchdogs with one request line each, and four watchdogs with two request lines each. A software trigger is the sixteenth source. Each source has its own enable bit in a control register. An enabled request that arrives while no reset is running drives the active-low system reset output low for a fixed number of cycles.

The block also records why each reset happened. A last-cause register holds one bit for the reset that happened most recently. An accumulated register collects the cause bit of every reset since software last cleared it. Both registers and the control register are cleared only by the power-on reset input, so software can read them after the global reset they caused.

Top module: `grst_recorder`

## Requirements
- R1: While `por` is high at a clock edge, the next cycle shows `sys_rst_n`=1, `last_cause`=0, `accum_cause`=0 and `ctrl_q`=0.
- R2: The control register is written when `wr_en`=1 and `wr_sel`=0. Its bits are: bit 0 software enable, bit 1 software trigger, bit 2 temperature sensor, bit 3 error monitor, bit 4 panic, bit 5 security, bit 6 self-test, bit 7 watchdog 1, bit 8 watchdog 2, bits 10:9 watchdog 3, bits 12:11 watchdog 4, bits 14:13 watchdog 5, and bits 16:15 watchdog 6. In each 2-bit field the low bit enables line 0 and the high bit enables line 1. A request whose enable is 0 causes no reset and changes no status. Bits 31:17 of `ctrl_q` read 0.
- R3: A software trigger written while the stored software-enable bit is 0 is discarded and reads back as 0. This holds even when the same write also sets the enable. A trigger written while the stored enable is 1 is kept, starts a reset at the next edge, and clears itself at that edge.
- R4: An enabled request that is high at a clock edge while no reset is running makes `sys_rst_n` 0 from the next cycle for exactly `PULSE_CYCLES` (default 32) cycles. After that, `sys_rst_n` returns to 1.
- R5: A request that arrives while a reset is running is ignored. It does not lengthen the pulse and it is not recorded.
- R6: When several enabled requests arrive at the same edge, only the one with the lowest status bit index is recorded. `last_cause` always has at most one bit set.
- R7: The status bit for each cause is: 0 temperature sensor, 2 error monitor, 3 panic, 4 security, 11 software, 12 self-test, 14 watchdog 1, 15/16 watchdog 3 lines 0/1, 17/18 watchdog 5 lines 0/1, 20 watchdog 2, 21/22 watchdog 4 lines 0/1, and 23/24 watchdog 6 lines 0/1. All other status bits read 0.
- R8: Each new reset replaces `last_cause` with that reset's cause bit alone.
- R9: Each recorded cause is ORed into `accum_cause`. A write with `wr_sel`=1 ANDs `accum_cause` with `wr_data`, so writing 0 clears it. A cause recorded in the same cycle as such a write is still kept.
- R10: A global reset pulse leaves `ctrl_q` (apart from the self-clearing trigger), `last_cause` and `accum_cause` unchanged once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 accumulated status |
| wr_data | input | 32 | Write data |
| ptsn_req | input | 1 | Temperature sensor alarm request |
| errm_req | input | 1 | Error-monitor request |
| panic_req | input | 1 | System panic request |
| secv_req | input | 1 | Security violation request |
| stest_fail | input | 1 | Self-test failure request |
| wdt1_req | input | 1 | Watchdog 1 request |
| wdt2_req | input | 1 | Watchdog 2 request |
| wdt3_req | input | 2 | Watchdog 3 request lines |
| wdt4_req | input | 2 | Watchdog 4 request lines |
| wdt5_req | input | 2 | Watchdog 5 request lines |
| wdt6_req | input | 2 | Watchdog 6 request lines |
| ctrl_q | output | 32 | Control register readback |
| sys_rst_n | output | 1 | Global system reset, active low |
| last_cause | output | 32 | Cause of the most recent global reset |
| accum_cause | output | 32 | Causes accumulated since the last clear |

## Verification
In one cycle a new reset cause can be recorded while software writes the accumulated register. The bench provokes this by driving a write of zero with `wr_sel`=1 and an enabled request on the same edge. It passes only if the new cause bit survives the clear. Priority is tested by raising four enabled sources on the same edge and checking that only the lowest status bit is recorded. A request is also raised partway through a running pulse; the bench checks that neither the pulse length nor either status register changes.

// File: rtl/grst_pkg.sv
package grst_pkg;

    localparam int STAT_W   = 32;
    localparam int NUM_PAIR = 4;

    // Status bit positions; software decodes these fields.
    localparam int B_PTSN  = 0;
    localparam int B_ERRM  = 2;
    localparam int B_PANIC = 3;
    localparam int B_SECV  = 4;
    localparam int B_SWR   = 11;
    localparam int B_STEST = 12;
    localparam int B_WDT1  = 14;
    localparam int B_WDT3  = 15;
    localparam int B_WDT5  = 17;
    localparam int B_WDT2  = 20;
    localparam int B_WDT4  = 21;
    localparam int B_WDT6  = 23;

    localparam logic [STAT_W-1:0] VALID_MASK = 32'h01F7_D81D;

    // Control register, least significant field last.
    typedef struct packed {
        logic [1:0] wdt6_en;
        logic [1:0] wdt5_en;
        logic [1:0] wdt4_en;
        logic [1:0] wdt3_en;
        logic       wdt2_en;
        logic       wdt1_en;
        logic       stest_en;
        logic       secv_en;
        logic       panic_en;
        logic       errm_en;
        logic       ptsn_en;
        logic       sw_trig;
        logic       sw_en;
    } grst_ctrl_t;

    localparam int CTRL_W = $bits(grst_ctrl_t);

    typedef enum logic {
        SEL_CTRL  = 1'b0,
        SEL_ACCUM = 1'b1
    } grst_sel_e;

    typedef struct packed {
        logic              fire;
        logic [STAT_W-1:0] cause;
    } grst_evt_t;

    // Pair index 0..3 covers watchdogs 3, 4, 5, 6.
    function automatic logic [2*NUM_PAIR-1:0] pair_enables(grst_ctrl_t c);
        return {c.wdt6_en, c.wdt5_en, c.wdt4_en, c.wdt3_en};
    endfunction

    function automatic int pair_base(int g);
        case (g)
            0:       return B_WDT3;
            1:       return B_WDT4;
            2:       return B_WDT5;
            default: return B_WDT6;
        endcase
    endfunction

endpackage

// File: rtl/grst_src_gate.sv
module grst_src_gate
    import grst_pkg::*;
(
    input  grst_ctrl_t                ctrl,
    input  logic                      ptsn,
    input  logic                      errm,
    input  logic                      panic,
    input  logic                      secv,
    input  logic                      stest,
    input  logic                      wdt1,
    input  logic                      wdt2,
    input  logic [2*NUM_PAIR-1:0]     pair_req,
    output logic [STAT_W-1:0]         req
);

    logic [2*NUM_PAIR-1:0] pair_en;
    assign pair_en = pair_enables(ctrl);

    always_comb begin
        req          = '0;
        req[B_PTSN]  = ptsn  & ctrl.ptsn_en;
        req[B_ERRM]  = errm  & ctrl.errm_en;
        req[B_PANIC] = panic & ctrl.panic_en;
        req[B_SECV]  = secv  & ctrl.secv_en;
        req[B_SWR]   = ctrl.sw_trig & ctrl.sw_en;
        req[B_STEST] = stest & ctrl.stest_en;
        req[B_WDT1]  = wdt1  & ctrl.wdt1_en;
        req[B_WDT2]  = wdt2  & ctrl.wdt2_en;
        for (int g = 0; g < NUM_PAIR; g++) begin
            req[pair_base(g) +: 2] = pair_req[2*g +: 2] & pair_en[2*g +: 2];
        end
    end

endmodule

// File: rtl/grst_first_pick.sv
module grst_first_pick #(
    parameter int W = 32
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] pick,
    output logic         any
);

    logic [W:0] seen;
    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_chain
            assign seen[i+1] = seen[i] | req[i];
            assign pick[i]   = req[i] & ~seen[i];
        end
    endgenerate

    assign any = seen[W];

endmodule

// File: rtl/grst_pulse_gen.sv
module grst_pulse_gen #(
    parameter int PULSE_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD); // R4

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R5

    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != 1) |=> busy); // R4

endmodule

// File: rtl/grst_status_regs.sv
module grst_status_regs
    import grst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  grst_evt_t         evt,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] last_q,
    output logic [STAT_W-1:0] accum_q
);

    logic [STAT_W-1:0] add_bits;
    logic [STAT_W-1:0] kept_bits;

    assign add_bits  = evt.fire ? evt.cause : '0;
    assign kept_bits = clr_we ? (accum_q & clr_mask) : accum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '0;
            accum_q <= '0;
        end else begin
            if (evt.fire) begin
                last_q <= evt.cause;
            end
            accum_q <= kept_bits | add_bits;
        end
    end

    AST_LAST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(last_q)); // R6

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((accum_q | last_q) & ~VALID_MASK) == '0); // R7

    AST_ACCUM_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((accum_q & $past(accum_q)) == $past(accum_q))); // R9

    AST_LAST_IN_ACCUM: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> ((accum_q & last_q) == last_q)); // R9

endmodule

// File: rtl/grst_recorder.sv
module grst_recorder
    import grst_pkg::*;
#(
    parameter int PULSE_CYCLES = 32
) (
    input  logic        clk,
    input  logic        por,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        ptsn_req,
    input  logic        errm_req,
    input  logic        panic_req,
    input  logic        secv_req,
    input  logic        stest_fail,
    input  logic        wdt1_req,
    input  logic        wdt2_req,
    input  logic [1:0]  wdt3_req,
    input  logic [1:0]  wdt4_req,
    input  logic [1:0]  wdt5_req,
    input  logic [1:0]  wdt6_req,
    output logic [31:0] ctrl_q,
    output logic        sys_rst_n,
    output logic [31:0] last_cause,
    output logic [31:0] accum_cause
);

    grst_sel_e             sel;
    grst_ctrl_t            ctrl_r;
    grst_ctrl_t            ctrl_wr;
    logic                  ctrl_we;
    logic                  accum_we;
    logic [STAT_W-1:0]     req;
    logic [STAT_W-1:0]     pick;
    logic                  any_req;
    logic                  busy;
    logic                  start;
    grst_evt_t             evt;
    logic [2*NUM_PAIR-1:0] pair_req;

    assign sel      = grst_sel_e'(wr_sel);
    assign ctrl_we  = wr_en && (sel == SEL_CTRL);
    assign accum_we = wr_en && (sel == SEL_ACCUM);
    assign pair_req = {wdt6_req, wdt5_req, wdt4_req, wdt3_req};

    // Trigger is only accepted when the stored enable is already set.
    always_comb begin
        ctrl_wr         = grst_ctrl_t'(wr_data[CTRL_W-1:0]);
        ctrl_wr.sw_trig = wr_data[1] & ctrl_r.sw_en;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            ctrl_r <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_r <= ctrl_wr;
            end
            if (start) begin
                ctrl_r.sw_trig <= 1'b0;
            end
        end
    end

    grst_src_gate u_gate (
        .ctrl     (ctrl_r),
        .ptsn     (ptsn_req),
        .errm     (errm_req),
        .panic    (panic_req),
        .secv     (secv_req),
        .stest    (stest_fail),
        .wdt1     (wdt1_req),
        .wdt2     (wdt2_req),
        .pair_req (pair_req),
        .req      (req)
    );

    grst_first_pick #(.W(STAT_W)) u_pick (
        .req  (req),
        .pick (pick),
        .any  (any_req)
    );

    assign start = any_req & ~busy;

    grst_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (por),
        .start (start),
        .busy  (busy)
    );

    assign evt.fire  = start;
    assign evt.cause = pick;

    grst_status_regs u_stat (
        .clk      (clk),
        .rst      (por),
        .evt      (evt),
        .clr_we   (accum_we),
        .clr_mask (wr_data),
        .last_q   (last_cause),
        .accum_q  (accum_cause)
    );

    assign sys_rst_n = ~busy;
    assign ctrl_q    = {{(32-CTRL_W){1'b0}}, ctrl_r};

    AST_PULSE_START: assert property (@(posedge clk) disable iff (por)
        start |=> !sys_rst_n); // R4

    AST_TRIG_GATED: assert property (@(posedge clk) disable iff (por)
        $rose(ctrl_r.sw_trig) |-> $past(ctrl_r.sw_en)); // R3

    AST_TRIG_SELFCLR: assert property (@(posedge clk) disable iff (por)
        start |=> !ctrl_r.sw_trig); // R3

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (por)
        busy |=> $stable(last_cause)); // R5

endmodule

// File: tb/sim_grst_recorder.sv
module sim_grst_recorder;

    logic        clk = 1'b0;
    logic        por;
    logic        wr_en;
    logic        wr_sel;
    logic [31:0] wr_data;
    logic        ptsn_req, errm_req, panic_req, secv_req, stest_fail;
    logic        wdt1_req, wdt2_req;
    logic [1:0]  wdt3_req, wdt4_req, wdt5_req, wdt6_req;
    logic [31:0] ctrl_q;
    logic        sys_rst_n;
    logic [31:0] last_cause;
    logic [31:0] accum_cause;

    always #2 clk = ~clk;

    grst_recorder #(.PULSE_CYCLES(32)) u0 (
        .clk(clk), .por(por), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ptsn_req(ptsn_req), .errm_req(errm_req), .panic_req(panic_req),
        .secv_req(secv_req), .stest_fail(stest_fail), .wdt1_req(wdt1_req),
        .wdt2_req(wdt2_req), .wdt3_req(wdt3_req), .wdt4_req(wdt4_req),
        .wdt5_req(wdt5_req), .wdt6_req(wdt6_req), .ctrl_q(ctrl_q),
        .sys_rst_n(sys_rst_n), .last_cause(last_cause), .accum_cause(accum_cause)
    );

    typedef struct {
        int          cyc;
        string       tag;
        logic        rn;
        logic [31:0] last;
        logic [31:0] accum;
        logic [31:0] ctrl;
    } exp_t;

    exp_t        sb[$];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] m_last = '0, m_accum = '0, m_ctrl = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compares every expected item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                chk(sb[i].tag, "sys_rst_n", {31'b0, sys_rst_n}, {31'b0, sb[i].rn});
                chk(sb[i].tag, "last_cause", last_cause, sb[i].last);
                chk(sb[i].tag, "accum_cause", accum_cause, sb[i].accum);
                chk(sb[i].tag, "ctrl_q", ctrl_q, sb[i].ctrl);
                sb.delete(i);
            end else if (sb[i].cyc < cyc) begin
                chk(sb[i].tag, "missed sample", 32'd0, 32'd1);
                sb.delete(i);
            end
        end
    end

    task automatic push(int d, string tag, logic rn);
        exp_t e;
        e.cyc = cyc + d; e.tag = tag; e.rn = rn;
        e.last = m_last; e.accum = m_accum; e.ctrl = m_ctrl;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick(1);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic int bit_of(int k);
        case (k)
            0: return 0;   1: return 2;   2: return 3;   3: return 4;
            4: return 12;  5: return 14;  6: return 15;  7: return 16;
            8: return 17;  9: return 18;  10: return 20; 11: return 21;
            12: return 22; 13: return 23; default: return 24;
        endcase
    endfunction

    task automatic set_src(int k, logic v);
        case (k)
            0: ptsn_req = v;     1: errm_req = v;     2: panic_req = v;
            3: secv_req = v;     4: stest_fail = v;   5: wdt1_req = v;
            6: wdt3_req[0] = v;  7: wdt3_req[1] = v;  8: wdt5_req[0] = v;
            9: wdt5_req[1] = v;  10: wdt2_req = v;    11: wdt4_req[0] = v;
            12: wdt4_req[1] = v; 13: wdt6_req[0] = v; default: wdt6_req[1] = v;
        endcase
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(20000 * 4);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        por = 1'b1; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        ptsn_req = 0; errm_req = 0; panic_req = 0; secv_req = 0; stest_fail = 0;
        wdt1_req = 0; wdt2_req = 0; wdt3_req = 0; wdt4_req = 0; wdt5_req = 0; wdt6_req = 0;
        tick(3);
        por = 1'b0;
        push(1, "R1 reset state", 1'b1);
        tick(1);

        // R2: disabled source is masked
        ptsn_req = 1'b1;
        push(1, "R2 disabled source masked", 1'b1);
        tick(1);
        ptsn_req = 1'b0;

        m_ctrl = 32'h0000_000C;
        push(1, "R2 control write", 1'b1);
        wr(1'b0, 32'h0000_000C);

        // R4 pulse length, R5 ignore during pulse
        errm_req = 1'b1;
        m_last = 32'h1 << 2; m_accum |= 32'h1 << 2;
        push(1, "R4 pulse starts", 1'b0);
        push(32, "R4 last low cycle", 1'b0);
        push(33, "R4 R5 pulse ends on time", 1'b1);
        tick(1);
        errm_req = 1'b0;
        tick(4);
        ptsn_req = 1'b1;
        push(1, "R5 request during pulse ignored", 1'b0);
        tick(1);
        ptsn_req = 1'b0;
        tick(30);

        // R6 same-cycle priority
        m_ctrl = 32'h0001_FFFC;
        push(1, "R2 all hardware enables", 1'b1);
        wr(1'b0, 32'h0001_FFFC);
        wdt6_req = 2'b11; wdt1_req = 1'b1; stest_fail = 1'b1; secv_req = 1'b1;
        m_last = 32'h1 << 4; m_accum |= 32'h1 << 4;
        push(1, "R6 lowest bit wins", 1'b0);
        tick(1);
        wdt6_req = 2'b00; wdt1_req = 1'b0; stest_fail = 1'b0; secv_req = 1'b0;
        tick(34);

        // R7 bit layout, R8 last cause replaced
        for (int k = 0; k < 15; k++) begin
            set_src(k, 1'b1);
            m_last = 32'h1 << bit_of(k);
            m_accum |= m_last;
            push(1, $sformatf("R7 R8 source %0d at bit %0d", k, bit_of(k)), 1'b0);
            tick(1);
            set_src(k, 1'b0);
            tick(34);
        end

        // R2 per-line enable of a two-line watchdog
        m_ctrl = 32'h0000_0800;
        push(1, "R2 watchdog 4 line 0 only", 1'b1);
        wr(1'b0, 32'h0000_0800);
        wdt4_req = 2'b10;
        push(1, "R2 masked watchdog line", 1'b1);
        tick(1);
        wdt4_req = 2'b01;
        m_last = 32'h1 << 21; m_accum |= m_last;
        push(1, "R2 enabled watchdog line", 1'b0);
        tick(1);
        wdt4_req = 2'b00;
        tick(34);

        // R3 software two-step
        m_ctrl = 32'h0;
        push(1, "R3 trigger without enable dropped", 1'b1);
        wr(1'b0, 32'h0000_0002);
        push(1, "R3 no reset from dropped trigger", 1'b1);
        tick(1);
        m_ctrl = 32'h1;
        push(1, "R3 enable and trigger in one write", 1'b1);
        wr(1'b0, 32'h0000_0003);
        push(1, "R3 still no reset", 1'b1);
        tick(1);
        m_ctrl = 32'h3;
        push(1, "R3 trigger stored", 1'b1);
        m_ctrl = 32'h1; m_last = 32'h1 << 11; m_accum |= m_last;
        push(2, "R3 software reset, trigger self-cleared", 1'b0);
        push(33, "R10 state during last low cycle", 1'b0);
        push(34, "R10 control and status survive pulse", 1'b1);
        wr(1'b0, 32'h0000_0003);
        tick(36);

        // R9 accumulated clear
        m_accum &= 32'h1 << 11;
        push(1, "R9 partial clear by mask", 1'b1);
        wr(1'b1, 32'h1 << 11);
        m_accum = '0;
        push(1, "R9 write zero clears", 1'b1);
        wr(1'b1, 32'h0);
        m_ctrl = 32'h5;
        push(1, "R9 enable temperature source", 1'b1);
        wr(1'b0, 32'h0000_0005);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 32'h0; ptsn_req = 1'b1;
        m_last = 32'h1; m_accum = 32'h1;
        push(1, "R9 cause kept over same-cycle clear", 1'b0);
        tick(1);
        wr_en = 1'b0; ptsn_req = 1'b0;
        tick(34);

        // R1 power-on reset clears everything
        por = 1'b1;
        m_last = '0; m_accum = '0; m_ctrl = '0;
        push(1, "R1 power-on clears status and control", 1'b1);
        tick(1);
        por = 1'b0;
        tick(3);

        if (sb.size() != 0) chk("scoreboard", "items left", sb.size(), 0);
        finish_run();
    end

endmodule